// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup Controller

This controller runs a direct-mapped line store that is treated as two halves. Each block has a home line. It also has a partner line at the same position in the other half, which is found by inverting the top bit of the index. A lookup first probes the home line. When that probe hits, the response comes back one cycle after the request is accepted and is flagged as a fast hit. When the home probe misses, the partner line is probed on the next cycle. A match there is returned as a slow hit, two cycles after acceptance.

When both probes miss, the controller issues a refill request to the next memory level. It holds that request until the refill data arrives and answers the requester in the same cycle the data arrives. Lines move between the two positions to keep recently used blocks in the fast position. On a slow hit the two lines trade places. On a refill the new block takes the home line, the displaced home block moves into the partner line, and whatever occupied the partner line is dropped.

Each stored line carries an absolute key: the address bits above the index plus the index top bit of the block's own home line. A line therefore stays identifiable in either half, and moving it never requires the key to be rewritten.

Top module: `pac_cache_ctrl`

## Requirements
- R1: Reset invalidates every line. Directly after reset, req_ready is 1 and rsp_valid and mem_req_valid are 0, and the first lookup of any address is a full miss.
- R2: When the home line (index = address bits [IDX_W-1:0]) holds the block, rsp_valid rises one cycle after the accepting edge, with rsp_fast=1, rsp_slow=0 and the stored data.
- R3: The partner line index equals the home index with bit IDX_W-1 inverted. Two addresses that share the upper bits and the low IDX_W-1 index bits, and differ only in that top index bit, compete for the same pair of lines.
- R4: When the home line misses and the partner line holds the block, rsp_valid rises two cycles after the accepting edge, with rsp_slow=1, rsp_fast=0 and the stored data.
- R5: After a slow hit, the two lines are exchanged. The next lookup of the same block is a fast hit, and the block that was in the home line becomes a slow hit.
- R6: On a full miss, mem_req_valid rises three cycles after acceptance, carrying mem_req_addr equal to the request address. Both stay steady until mem_rsp_valid. The response appears in the mem_rsp_valid cycle with rsp_fast=0, rsp_slow=0 and rsp_data=mem_rsp_data.
- R7: A refill writes the new block into the home line and moves the previous valid home block into the partner line, discarding the partner's former contents.
- R8: If the home line was empty at refill, the partner line keeps its contents.
- R9: req_ready is 1 only when the controller is idle. A request presented while busy is not taken, and mem_rsp_valid outside a pending refill produces no response and changes no line.
- R10: rsp_fast and rsp_slow are never both 1, and neither is 1 without rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Block address of the lookup |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_fast | output | 1 | Response is a home-line hit |
| rsp_slow | output | 1 | Response is a partner-line hit |
| rsp_data | output | DATA_W | Returned block data |
| mem_req_valid | output | 1 | Refill request to next level |
| mem_req_addr | output | ADDR_W | Address being refilled |
| mem_rsp_valid | input | 1 | Refill data present |
| mem_rsp_data | input | DATA_W | Refill data |

## Verification
The stimulus repeatedly pits a conflicting pair of blocks against a third block that shares the same line pair.

- **Refill placement.** A controller that refilled the partner line, or that failed to move the old home block across, would turn later fast hits into misses or slow hits.
- **Swap on a slow hit.** A missing or one-sided swap shows up as a second slow hit, or as a block that vanishes.
- **Refill into an empty home line.** Moving an empty home line into the partner position on such a refill would wipe a valid neighbour.
- **Strays while busy.** Requests presented mid-refill and refill data arriving while idle must leave no trace. A controller that accepted either would later report a hit for a block that was never filled, or return corrupted data.

// File: rtl/pac_pkg.sv
`timescale 1ns/1ps
package pac_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRIM = 2'd1,
      ST_ALT  = 2'd2,
      ST_FILL = 2'd3
   } pac_state_e;

endpackage

// File: rtl/pac_line_store.sv
`timescale 1ns/1ps
// Flip-flop line store: two combinational read ports and two write ports.
// Port A has priority, although the controller never aims both at one line.
module pac_line_store #(
   parameter int IDX_W  = 3,
   parameter int KEY_W  = 14,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_p_idx,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic              rd_p_vld,
   output logic [KEY_W-1:0]  rd_p_key,
   output logic [DATA_W-1:0] rd_p_dat,
   output logic              rd_a_vld,
   output logic [KEY_W-1:0]  rd_a_key,
   output logic [DATA_W-1:0] rd_a_dat,
   input  logic              wa_en,
   input  logic [IDX_W-1:0]  wa_idx,
   input  logic              wa_vld,
   input  logic [KEY_W-1:0]  wa_key,
   input  logic [DATA_W-1:0] wa_dat,
   input  logic              wb_en,
   input  logic [IDX_W-1:0]  wb_idx,
   input  logic              wb_vld,
   input  logic [KEY_W-1:0]  wb_key,
   input  logic [DATA_W-1:0] wb_dat
);
   localparam int DEPTH = 1 << IDX_W;

   logic              vld_w [DEPTH];
   logic [KEY_W-1:0]  key_w [DEPTH];
   logic [DATA_W-1:0] dat_w [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_line
      logic              vld_q;
      logic [KEY_W-1:0]  key_q;
      logic [DATA_W-1:0] dat_q;
      logic              sel_a, sel_b;

      assign sel_a = wa_en && (wa_idx == IDX_W'(e));
      assign sel_b = wb_en && (wb_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     vld_q <= 1'b0;
         else if (sel_a) vld_q <= wa_vld;
         else if (sel_b) vld_q <= wb_vld;
      end

      always_ff @(posedge clk) begin
         if (sel_a) begin
            key_q <= wa_key;
            dat_q <= wa_dat;
         end else if (sel_b) begin
            key_q <= wb_key;
            dat_q <= wb_dat;
         end
      end

      assign vld_w[e] = vld_q;
      assign key_w[e] = key_q;
      assign dat_w[e] = dat_q;
   end

   assign rd_p_vld = vld_w[rd_p_idx];
   assign rd_p_key = key_w[rd_p_idx];
   assign rd_p_dat = dat_w[rd_p_idx];
   assign rd_a_vld = vld_w[rd_a_idx];
   assign rd_a_key = key_w[rd_a_idx];
   assign rd_a_dat = dat_w[rd_a_idx];

endmodule

// File: rtl/pac_probe_cmp.sv
`timescale 1ns/1ps
// Key comparator for one probe position.
module pac_probe_cmp #(
   parameter int KEY_W = 14
) (
   input  logic             line_vld,
   input  logic [KEY_W-1:0] line_key,
   input  logic [KEY_W-1:0] want_key,
   output logic             hit
);
   assign hit = line_vld && (line_key == want_key);
endmodule

// File: rtl/pac_probe_seq.sv
`timescale 1ns/1ps
// Probe sequencer: home probe, then partner probe, then refill wait.
module pac_probe_seq
   import pac_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_fire,
   input  logic       hit_p,
   input  logic       hit_a,
   input  logic       fill_arrive,
   output pac_state_e state
);
   pac_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (req_fire)   nxt = ST_PRIM;
         ST_PRIM: nxt = hit_p ? ST_IDLE : ST_ALT;
         ST_ALT:  nxt = hit_a ? ST_IDLE : ST_FILL;
         ST_FILL: if (fill_arrive) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/pac_cache_ctrl.sv
`timescale 1ns/1ps
// Pseudo-associative lookup controller, top level.
module pac_cache_ctrl
   import pac_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int IDX_W        = 3,
   parameter int DATA_W       = 32,
   parameter bit PROMOTE_SLOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_fast,
   output logic              rsp_slow,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   localparam int TAG_W = ADDR_W - IDX_W;
   localparam int KEY_W = TAG_W + 1;
   localparam logic [IDX_W-1:0] HALF_MASK = IDX_W'(1) << (IDX_W - 1);

   if (IDX_W < 1) begin : g_bad_idx
      $error("pac_cache_ctrl: IDX_W must be at least 1");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("pac_cache_ctrl: ADDR_W must exceed IDX_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("pac_cache_ctrl: DATA_W must be positive");
   end

   pac_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic [IDX_W-1:0]  idx_p, idx_a;
   logic [KEY_W-1:0]  want_key;
   logic              req_fire, hit_p, hit_a;
   logic              p_vld, a_vld;
   logic [KEY_W-1:0]  p_key, a_key;
   logic [DATA_W-1:0] p_dat, a_dat;
   logic              fill_done, swap_en;

   assign req_ready = (state == ST_IDLE);
   assign req_fire  = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr_q <= '0;
      else if (req_fire) addr_q <= req_addr;
   end

   // Partner line: top index bit inverted. The key records the home half.
   assign idx_p    = addr_q[IDX_W-1:0];
   assign idx_a    = idx_p ^ HALF_MASK;
   assign want_key = {addr_q[ADDR_W-1:IDX_W], addr_q[IDX_W-1]};

   pac_probe_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_fire    (req_fire),
      .hit_p       (hit_p),
      .hit_a       (hit_a),
      .fill_arrive (mem_rsp_valid),
      .state       (state)
   );

   pac_probe_cmp #(.KEY_W(KEY_W)) u_cmp_p (
      .line_vld (p_vld), .line_key (p_key), .want_key (want_key), .hit (hit_p)
   );
   pac_probe_cmp #(.KEY_W(KEY_W)) u_cmp_a (
      .line_vld (a_vld), .line_key (a_key), .want_key (want_key), .hit (hit_a)
   );

   assign rsp_fast  = (state == ST_PRIM) && hit_p;
   assign rsp_slow  = (state == ST_ALT)  && hit_a;
   assign fill_done = (state == ST_FILL) && mem_rsp_valid;
   assign rsp_valid = rsp_fast || rsp_slow || fill_done;
   assign rsp_data  = rsp_fast ? p_dat : (rsp_slow ? a_dat : mem_rsp_data);

   assign mem_req_valid = (state == ST_FILL);
   assign mem_req_addr  = addr_q;

   if (PROMOTE_SLOW) begin : g_promote
      assign swap_en = rsp_slow;
   end else begin : g_static
      assign swap_en = 1'b0;
   end

   // Port A: home line gets the promoted or refilled block.
   // Port B: partner line gets the former home block.
   logic              wa_en, wb_en;
   logic [DATA_W-1:0] wa_dat;

   assign wa_en  = swap_en || fill_done;
   assign wa_dat = swap_en ? a_dat : mem_rsp_data;
   assign wb_en  = swap_en || (fill_done && p_vld);

   pac_line_store #(.IDX_W(IDX_W), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_p_idx (idx_p),
      .rd_a_idx (idx_a),
      .rd_p_vld (p_vld),
      .rd_p_key (p_key),
      .rd_p_dat (p_dat),
      .rd_a_vld (a_vld),
      .rd_a_key (a_key),
      .rd_a_dat (a_dat),
      .wa_en    (wa_en),
      .wa_idx   (idx_p),
      .wa_vld   (1'b1),
      .wa_key   (want_key),
      .wa_dat   (wa_dat),
      .wb_en    (wb_en),
      .wb_idx   (idx_a),
      .wb_vld   (p_vld),
      .wb_key   (p_key),
      .wb_dat   (p_dat)
   );

endmodule

// File: rtl/pac_cache_ctrl_chk.sv
`timescale 1ns/1ps
module pac_cache_ctrl_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_fast,
   input logic              rsp_slow,
   input logic              mem_req_valid,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_rsp_valid
);
   a_r2_fast_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fast) |-> $past(req_valid && req_ready));

   a_r4_slow_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_slow) |-> $past(req_valid && req_ready, 2));

   a_r10_kind_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_fast, rsp_slow}));

   a_r10_kind_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fast || rsp_slow) |-> rsp_valid);

   a_r6_refill_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

   a_r6_miss_reply_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fast && !rsp_slow) |-> (mem_req_valid && mem_rsp_valid));

   a_r9_idle_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!rsp_valid && !mem_req_valid));
endmodule

bind pac_cache_ctrl pac_cache_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_fast      (rsp_fast),
   .rsp_slow      (rsp_slow),
   .mem_req_valid (mem_req_valid),
   .mem_req_addr  (mem_req_addr),
   .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/pac_cache_ctrl_test.sv
`timescale 1ns/1ps
module pac_cache_ctrl_test;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int K_MISS = 0, K_FAST = 1, K_SLOW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid, rsp_fast, rsp_slow;
   logic [DW-1:0] rsp_data;
   logic          mem_req_valid;
   logic [AW-1:0] mem_req_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [DW-1:0] mem_rsp_data = '0;

   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   pac_cache_ctrl #(.ADDR_W(AW), .IDX_W(3), .DATA_W(DW)) uut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .rsp_valid (rsp_valid), .rsp_fast (rsp_fast), .rsp_slow (rsp_slow),
      .rsp_data (rsp_data),
      .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data)
   );

   // Blocks used below (IDX_W=3, top index bit = addr[2]); the R3 pair is A/B:
   // A=0010 home 0, B=0014 home 4, C=0020 home 0, D=0034 home 4, E=0011 home 1.
   localparam logic [17:0] VEC [22] = '{
      {2'd0, 16'h0010}, {2'd1, 16'h0010}, {2'd0, 16'h0014}, {2'd1, 16'h0010},
      {2'd1, 16'h0014}, {2'd0, 16'h0020}, {2'd1, 16'h0020}, {2'd2, 16'h0010},
      {2'd1, 16'h0010}, {2'd2, 16'h0020}, {2'd0, 16'h0014}, {2'd1, 16'h0010},
      {2'd1, 16'h0014}, {2'd0, 16'h0020}, {2'd0, 16'h0034}, {2'd1, 16'h0010},
      {2'd0, 16'h0020}, {2'd0, 16'h0034}, {2'd0, 16'h0011}, {2'd1, 16'h0011},
      {2'd1, 16'h0010}, {2'd1, 16'h0034}
   };

   function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
      return {a ^ 16'h5A5A, ~a};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(req_ready === 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
      chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
      chk(mem_req_valid === 1'b0, "R1", "mem_req after reset", 64'(mem_req_valid), 64'd0);
   endtask

   task automatic run_req(input logic [AW-1:0] a, input int kind, input int dly,
                          input string rq);
      int lat;
      @(negedge clk);
      chk(req_ready === 1'b1, "R9", "ready before request", 64'(req_ready), 64'd1);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      lat = 1;
      if (kind == K_MISS) begin
         while (!rsp_valid && !mem_req_valid && lat < 10) begin
            @(negedge clk); #1; lat++;
         end
         chk(mem_req_valid === 1'b1 && lat == 3, rq, "refill request cycle",
             64'(lat), 64'd3);
         chk(mem_req_addr === a, "R6", "refill address", 64'(mem_req_addr), 64'(a));
         for (int w = 0; w < dly; w++) begin
            @(negedge clk); #1;
            chk(mem_req_valid === 1'b1 && mem_req_addr === a && !rsp_valid, "R6",
                "refill held", 64'(mem_req_valid), 64'd1);
         end
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = mdata(a);
         #1;
         chk(rsp_valid === 1'b1 && !rsp_fast && !rsp_slow, rq, "miss response kind",
             64'({rsp_valid, rsp_fast, rsp_slow}), 64'b100);
         chk(rsp_data === mdata(a), "R6", "miss data", 64'(rsp_data), 64'(mdata(a)));
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         mem_rsp_data  = '0;
      end else begin
         while (!rsp_valid && lat < 8) begin
            @(negedge clk); #1; lat++;
         end
         chk(lat == kind, rq, "hit latency", 64'(lat), 64'(kind));
         chk(rsp_valid === 1'b1 && rsp_fast === (kind == K_FAST) &&
             rsp_slow === (kind == K_SLOW), "R10", "hit kind flags",
             64'({rsp_valid, rsp_fast, rsp_slow}),
             64'({1'b1, kind == K_FAST, kind == K_SLOW}));
         chk(rsp_data === mdata(a), rq, "hit data", 64'(rsp_data), 64'(mdata(a)));
      end
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      do_reset();  // R1

      // Table walk: R2 fast hits, R4/R5 slow hits with swap, R6/R7 refills,
      // R8 refill with empty home line (vector 2 then 3).
      for (int i = 0; i < 22; i++) begin
         int k;
         string rq;
         k = int'(VEC[i][17:16]);
         if (k == K_MISS)      rq = (i == 0) ? "R1" : ((i == 2) ? "R8" : "R7");
         else if (k == K_FAST) rq = (i == 3) ? "R8" : ((i == 8) ? "R5" : "R2");
         else                  rq = (i == 9) ? "R5" : "R4";
         if (i == 2 || i == 5) rq = {rq, " R3"};
         run_req(VEC[i][15:0], k, i % 3, rq);
      end

      // R9: a request presented during a refill wait is not taken.
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 16'h0042;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk(mem_req_valid === 1'b1, "R9", "refill pending", 64'(mem_req_valid), 64'd1);
      req_valid = 1'b1;
      req_addr  = 16'h0055;
      #1;
      chk(req_ready === 1'b0, "R9", "ready while busy", 64'(req_ready), 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(rsp_valid === 1'b0, "R9", "no reply while waiting", 64'(rsp_valid), 64'd0);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mdata(16'h0042);
      #1;
      chk(rsp_valid === 1'b1 && rsp_data === mdata(16'h0042), "R6", "busy-case fill data",
          64'(rsp_data), 64'(mdata(16'h0042)));
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      run_req(16'h0055, K_MISS, 1, "R9");  // the stray request left no line

      // R9: refill data while idle produces nothing and changes nothing.
      @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'hDEAD_BEEF;
      #1;
      chk(rsp_valid === 1'b0, "R9", "stray refill reply", 64'(rsp_valid), 64'd0);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      run_req(16'h0010, K_FAST, 0, "R9");
      run_req(16'h0042, K_FAST, 0, "R9");

      // R1: a second reset invalidates lines that were resident.
      do_reset();
      run_req(16'h0010, K_MISS, 0, "R1");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule